// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Core

This block is the protocol side of a byte-wide memory that sits on a two-wire serial bus as a slave. It does not see the raw bus lines. A front-end filter hands it single-cycle strobes for SCL rising, SCL falling, a start condition and a stop condition, plus the settled SDA level. The block returns one registered signal, an enable for the open-drain pull-down on SDA. Each stored byte has a 17-bit address. The most significant address bit travels inside the select byte, and the other sixteen bits arrive in two address bytes.

Data bytes received during a write go into a page buffer first. A stop that lands exactly on a byte boundary, after an acknowledged data byte, commits them. The buffer then copies its valid entries into a synchronous memory array and holds a busy window for a programmable number of cycles. While that window is open the core stays silent on the bus, so a master can poll the acknowledge to learn when the write has finished. Reads stream bytes from an internal address counter. The array holds 2**MEM_AW bytes and is indexed by the low MEM_AW bits of the 17-bit address.

Top module: `i2c_eeprom_core`

## Requirements
- R1: A select byte is acknowledged only if its bits 7:4 are 1010 and its bits 3:2 equal `chip_sel`. On any other value the core does not acknowledge, and it ignores the rest of the transfer up to the next start.
- R2: After a select byte with bit 0 equal to 0, two address bytes follow, high byte first. Both are acknowledged. The byte address is {select bit 1, high byte, low byte}.
- R3: While `wr_lock` is low, each data byte is acknowledged and buffered. After each byte only the low 7 address bits advance, so a page write wraps inside its 128-byte row. A stop received right after an acknowledge slot writes the buffered bytes to the array.
- R4: A stop received in the middle of a data byte discards the buffered bytes. The array is unchanged and no busy window follows. A start received after buffered data also discards them.
- R5: The core samples `wr_lock` when the second address byte completes. If it is high, the select and address bytes are still acknowledged, every data byte gets a NoAck, and the array is left unchanged.
- R6: From a commit until the write window ends, the core acknowledges nothing, including its own select byte. Afterwards it acknowledges again.
- R7: A select byte with bit 0 equal to 1 returns the byte at the internal counter and then adds one to the counter.
- R8: A random read is a write select plus two address bytes, then a repeated start and a read select. It returns the byte at the loaded address.
- R9: An Ack from the master in the slot after a read byte makes the core send the next byte. A NoAck puts the core in standby, and it drives SDA on no later clock.
- R10: During reads the 17-bit counter wraps from 0x1FFFF to 0x00000. The array index is the low MEM_AW bits of the address.
- R11: The core drives read bits MSB first, each one changing after SCL falls. It releases SDA in the slot where the master acknowledges. It asserts its own acknowledge after the eighth SCL fall and releases it on the fall that ends the slot.
- R12: A start received in any state, including partway through a byte, aborts the transfer and waits for a fresh select byte.
- R13: After reset the SDA pull-down is off and the core accepts a select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_rise | input | 1 | One-cycle strobe on a filtered SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on a filtered SCL falling edge |
| start_det | input | 1 | One-cycle strobe on a start or repeated start |
| stop_det | input | 1 | One-cycle strobe on a stop condition |
| sda_in | input | 1 | Filtered SDA level, sampled on `scl_rise` |
| chip_sel | input | 2 | Strap value compared with select bits 3:2 |
| wr_lock | input | 1 | Write protect; high blocks data bytes |
| sda_pull | output | 1 | Registered enable of the SDA pull-down |

## Verification
Assertions check the following on every cycle:
- The pull-down never rises outside an acknowledge slot or a read byte.
- The pull-down is off in standby and throughout a write window.
- SDA is released in the master's acknowledge slot.
- Each read byte advances the counter by one, modulo 2**17.
- The buffer never accepts a byte or a commit while it is flushing, and every array write falls inside the busy window.

Some properties depend on what was stored at another address earlier, so only the bench's scenarios can show them:
- Memory stays unchanged after a locked write or an aborted write.
- A page write wraps inside its row.
- The counter wraps from the top of the address space to zero.
- A master can poll the acknowledge through the busy window.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int          BYTE_ADDR_W = 17;
  localparam logic [3:0]  DEV_TYPE    = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVSEL, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA
  } ee_state_e;
endpackage

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int ADDR_W = 17,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr[AW-1:0]] <= wdata;
    rdata <= ram[raddr[AW-1:0]];
  end

  generate
    if (AW < ADDR_W) begin : g_alias
      logic unused_hi_bits;
      assign unused_hi_bits = ^{waddr[ADDR_W-1:AW], raddr[ADDR_W-1:AW]};
    end
  endgenerate
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 7,
  parameter int WR_HOLD = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              commit,
  input  logic              discard,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE   = 1 << PAGE_AW;
  localparam int ROW_W  = ADDR_W - PAGE_AW;
  localparam int HOLD_W = $clog2(WR_HOLD + 1);

  typedef enum logic [1:0] {PB_IDLE, PB_FLUSH, PB_HOLD} pb_e;

  logic [7:0]         buf_q [PAGE];
  logic [PAGE-1:0]    vld_q;
  logic [ROW_W-1:0]   row_q;
  logic [PAGE_AW-1:0] idx_q;
  logic [HOLD_W-1:0]  hold_q;
  pb_e                ph_q;

  // Storage and registered read: no reset, so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_addr[PAGE_AW-1:0]] <= wr_data;
    mem_wdata <= buf_q[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PB_IDLE;
      vld_q     <= '0;
      row_q     <= '0;
      idx_q     <= '0;
      hold_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
    end else begin
      mem_we    <= (ph_q == PB_FLUSH) && vld_q[idx_q];
      mem_waddr <= {row_q, idx_q};
      case (ph_q)
        PB_IDLE: begin
          if (wr_en) begin
            vld_q[wr_addr[PAGE_AW-1:0]] <= 1'b1;
            row_q <= wr_addr[ADDR_W-1:PAGE_AW];
          end
          if (discard) vld_q <= '0;
          else if (commit) begin
            ph_q  <= PB_FLUSH;
            idx_q <= '0;
          end
        end
        PB_FLUSH: begin
          idx_q <= idx_q + PAGE_AW'(1);
          if (idx_q == {PAGE_AW{1'b1}}) begin
            ph_q   <= PB_HOLD;
            hold_q <= HOLD_W'(WR_HOLD);
          end
        end
        default: begin
          if (hold_q == '0) begin
            ph_q  <= PB_IDLE;
            vld_q <= '0;
          end else begin
            hold_q <= hold_q - HOLD_W'(1);
          end
        end
      endcase
    end
  end

  assign busy = (ph_q != PB_IDLE);

  assert_write_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  assert_no_fill_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en || commit) |-> (ph_q == PB_IDLE));
endmodule

// File: rtl/ee_proto.sv
module ee_proto
  import ee_pkg::*;
#(
  parameter int PAGE_AW = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   sda_in,
  input  logic [1:0]             chip_sel,
  input  logic                   wr_lock,
  input  logic                   busy,
  output logic                   sda_pull,
  output logic                   lat_we,
  output logic [BYTE_ADDR_W-1:0] lat_addr,
  output logic [7:0]             lat_data,
  output logic                   commit,
  output logic                   discard,
  output logic [BYTE_ADDR_W-1:0] rd_addr,
  input  logic [7:0]             rd_data
);
  ee_state_e              st_q;
  logic [3:0]             cnt_q;     // rising edges seen in this byte frame, 8 = ack slot
  logic [6:0]             sh_q;
  logic [6:0]             tx_q;
  logic                   ack_q;     // slave acknowledges the current slot
  logic                   rd_slot_q; // the current slot belongs to the master
  logic                   a16_q;
  logic [7:0]             ahi_q;
  logic [BYTE_ADDR_W-1:0] addr_q;
  logic                   lock_q;
  logic                   have_q;
  logic [7:0]             byte_in;

  assign byte_in = {sh_q, sda_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  tx_q <= '0;
      ack_q <= 1'b0;  rd_slot_q <= 1'b0;  a16_q <= 1'b0;  ahi_q <= '0;
      addr_q <= '0;  lock_q <= 1'b0;  have_q <= 1'b0;  sda_pull <= 1'b0;
      lat_we <= 1'b0;  lat_addr <= '0;  lat_data <= '0;
      commit <= 1'b0;  discard <= 1'b0;
    end else begin
      lat_we  <= 1'b0;
      commit  <= 1'b0;
      discard <= 1'b0;
      if (start_det) begin
        st_q <= ST_DEVSEL;  cnt_q <= '0;  ack_q <= 1'b0;
        rd_slot_q <= 1'b0;  sda_pull <= 1'b0;
        discard <= have_q;
        have_q  <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;  cnt_q <= '0;  ack_q <= 1'b0;
        rd_slot_q <= 1'b0;  sda_pull <= 1'b0;
        if (have_q) begin
          if (st_q == ST_WDATA && cnt_q == 4'd0) commit <= 1'b1;
          else discard <= 1'b1;
        end
        have_q <= 1'b0;
      end else if (scl_rise && st_q != ST_IDLE) begin
        if (cnt_q == 4'd8) begin
          cnt_q <= '0;  ack_q <= 1'b0;  rd_slot_q <= 1'b0;
          if (rd_slot_q && sda_in) st_q <= ST_IDLE;   // master NoAck: standby
        end else begin
          sh_q  <= byte_in[6:0];
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            case (st_q)
              ST_DEVSEL: begin
                if (byte_in[7:4] == DEV_TYPE && byte_in[3:2] == chip_sel && !busy) begin
                  ack_q <= 1'b1;
                  if (byte_in[0]) st_q <= ST_RDATA;
                  else begin
                    a16_q <= byte_in[1];
                    st_q  <= ST_AHI;
                  end
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                ahi_q <= byte_in;  ack_q <= 1'b1;  st_q <= ST_ALO;
              end
              ST_ALO: begin
                addr_q <= {a16_q, ahi_q, byte_in};
                lock_q <= wr_lock;  ack_q <= 1'b1;  st_q <= ST_WDATA;
              end
              ST_WDATA: begin
                if (!lock_q) begin
                  ack_q <= 1'b1;  lat_we <= 1'b1;
                  lat_addr <= addr_q;  lat_data <= byte_in;  have_q <= 1'b1;
                  addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + PAGE_AW'(1);
                end
              end
              ST_RDATA: rd_slot_q <= 1'b1;
              default: ;
            endcase
          end
        end
      end else if (scl_fall && st_q != ST_IDLE) begin
        if (cnt_q == 4'd8) begin
          sda_pull <= ack_q;
        end else if (st_q == ST_RDATA) begin
          if (cnt_q == 4'd0) begin
            tx_q     <= rd_data[6:0];
            sda_pull <= ~rd_data[7];
            addr_q   <= addr_q + BYTE_ADDR_W'(1);
          end else begin
            tx_q     <= {tx_q[5:0], 1'b0};
            sda_pull <= ~tx_q[6];
          end
        end else begin
          sda_pull <= 1'b0;
        end
      end
    end
  end

  assign rd_addr = addr_q;

  assert_quiet_in_standby_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !sda_pull);
  assert_silent_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull);
  assert_pull_only_in_slot_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> (cnt_q == 4'd8 || st_q == ST_RDATA));
  assert_master_slot_free_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && !start_det && !stop_det && !scl_rise && rd_slot_q && cnt_q == 4'd8)
      |=> !sda_pull);
  assert_rd_counter_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && !start_det && !stop_det && !scl_rise && st_q == ST_RDATA && cnt_q == 4'd0)
      |=> (addr_q == $past(addr_q) + BYTE_ADDR_W'(1)));
endmodule

// File: rtl/i2c_eeprom_core.sv
module i2c_eeprom_core
  import ee_pkg::*;
#(
  parameter int PAGE_AW = 7,
  parameter int MEM_AW  = 10,
  parameter int WR_HOLD = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_in,
  input  logic [1:0] chip_sel,
  input  logic       wr_lock,
  output logic       sda_pull
);
  logic                   lat_we, commit, discard, busy, mem_we;
  logic [BYTE_ADDR_W-1:0] lat_addr, rd_addr, mem_waddr;
  logic [7:0]             lat_data, rd_data, mem_wdata;

  ee_proto #(.PAGE_AW(PAGE_AW)) u_proto (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_in),
    .chip_sel(chip_sel), .wr_lock(wr_lock), .busy(busy), .sda_pull(sda_pull),
    .lat_we(lat_we), .lat_addr(lat_addr), .lat_data(lat_data),
    .commit(commit), .discard(discard), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  ee_page_buf #(.ADDR_W(BYTE_ADDR_W), .PAGE_AW(PAGE_AW), .WR_HOLD(WR_HOLD)) u_page (
    .clk(clk), .rst(rst), .wr_en(lat_we), .wr_addr(lat_addr), .wr_data(lat_data),
    .commit(commit), .discard(discard), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  ee_mem_array #(.ADDR_W(BYTE_ADDR_W), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/test_i2c_eeprom_core.sv
module test_i2c_eeprom_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 10;
  localparam int WR_HOLD    = 200;
  localparam int GAP        = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_rise = 1'b0, scl_fall = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic m_sda = 1'b1, wr_lock = 1'b0;
  logic [1:0] chip_sel = 2'b10;
  logic sda_pull, sda_in;
  int checks = 0, errors = 0;

  logic [7:0] ref_mem [1 << MEM_AW];
  logic [7:0] wbuf [8];

  assign sda_in = m_sda & ~sda_pull;

  i2c_eeprom_core #(.MEM_AW(MEM_AW), .WR_HOLD(WR_HOLD)) i_i2c_eeprom_core (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_in),
    .chip_sel(chip_sel), .wr_lock(wr_lock), .sda_pull(sda_pull));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [MEM_AW-1:0] midx(input logic [16:0] a);
    return a[MEM_AW-1:0];
  endfunction
  function automatic logic [16:0] in_row(input logic [16:0] base, input int k);
    return {base[16:7], 7'(int'(base[6:0]) + k)};
  endfunction
  function automatic logic [7:0] sel(input logic a16, input logic rw);
    return {4'b1010, chip_sel, a16, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic strobe(input int which);
    @(negedge clk);
    case (which) 0: scl_rise = 1; 1: scl_fall = 1; 2: start_det = 1; default: stop_det = 1; endcase
    @(negedge clk);
    scl_rise = 0; scl_fall = 0; start_det = 0; stop_det = 0;
  endtask

  task automatic bus_start(); @(negedge clk) m_sda = 1; strobe(2); strobe(1); idle(GAP); endtask
  task automatic bus_stop(); strobe(3); idle(GAP); endtask

  task automatic put_bit(input logic b);
    @(negedge clk) m_sda = b; idle(GAP); strobe(0); idle(GAP); strobe(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    @(negedge clk) m_sda = 1; idle(GAP);
    acked = !sda_in;
    strobe(0); idle(GAP); strobe(1); idle(GAP);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b, output logic slot_pull);
    for (int i = 7; i >= 0; i--) begin
      idle(GAP); b[i] = sda_in; strobe(0); idle(GAP); strobe(1);
    end
    @(negedge clk) m_sda = !mack; idle(GAP);
    slot_pull = sda_pull;
    strobe(0); idle(GAP); strobe(1);
    @(negedge clk) m_sda = 1; idle(GAP);
  endtask

  task automatic do_write(input logic [16:0] a, input int n, input logic lock, input string req);
    logic ack;
    @(negedge clk) wr_lock = lock;
    bus_start();
    send_byte(sel(a[16], 1'b0), ack); chk({req, " select ack (R2)"}, ack, 1);
    send_byte(a[15:8], ack);          chk({req, " high address ack (R2)"}, ack, 1);
    send_byte(a[7:0], ack);           chk({req, " low address ack (R2)"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      chk({req, " data ack"}, ack, !lock);
      if (!lock) ref_mem[midx(in_row(a, k))] = wbuf[k];
    end
    bus_stop();
    @(negedge clk) wr_lock = 0;
  endtask

  task automatic wait_ready(input string req);
    logic ack = 0;
    for (int p = 0; p < 40 && !ack; p++) begin
      bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    end
    chk({req, " device returns to acknowledging (R6)"}, ack, 1);
  endtask

  task automatic do_read(input logic [16:0] a, input int n, input string req);
    logic ack, slot;
    logic [7:0] b;
    bus_start();
    send_byte(sel(a[16], 1'b0), ack); chk({req, " dummy write select (R8)"}, ack, 1);
    send_byte(a[15:8], ack);          chk({req, " dummy high address (R8)"}, ack, 1);
    send_byte(a[7:0], ack);           chk({req, " dummy low address (R8)"}, ack, 1);
    bus_start();
    send_byte(sel(a[16], 1'b1), ack); chk({req, " read select ack (R8)"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b, slot);
      chk({req, " read data"}, b, ref_mem[midx(17'(a + 17'(k)))]);
      chk({req, " master slot released (R11)"}, slot, 0);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack, slot;
    logic [7:0] b;
    logic [16:0] ra;
    int n;
    void'($urandom(32'h5EED_0042));
    idle(4);
    @(negedge clk) rst = 0;
    idle(2);
    chk("R13 pull-down off after reset", sda_pull, 0);

    // R1: wrong chip code and wrong type nibble
    bus_start();
    send_byte({4'b1010, ~chip_sel, 2'b00}, ack); chk("R1 wrong chip code NoAck", ack, 0);
    send_byte(8'h00, ack);                       chk("R1 rest of transfer ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, chip_sel, 2'b00}, ack);  chk("R1 wrong type nibble NoAck", ack, 0);
    bus_stop();
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack);             chk("R13 select accepted after reset", ack, 1);
    bus_stop();

    // R3, R6, R7, R8: page write of two bytes, poll, random and current read
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    do_write(17'h00123, 2, 1'b0, "R3 page write");
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk("R6 select NoAck during write window", ack, 0);
    wait_ready("R6");
    do_read(17'h00123, 1, "R8 random read");
    bus_start();
    send_byte(sel(1'b0, 1'b1), ack); chk("R7 current read select ack", ack, 1);
    recv_byte(1'b0, b, slot);
    chk("R7 current read returns next byte", b, 8'hC3);
    chk("R11 master slot released (R7)", slot, 0);
    bus_stop();

    // R3: row wrap inside a page write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(17'h0047E, 3, 1'b0, "R3 row wrap");
    wait_ready("R3");
    do_read(17'h00400, 1, "R3 wrapped byte at row start");
    do_read(17'h0047E, 2, "R3 bytes before wrap");

    // R5: write lock
    wbuf[0] = 8'hFF;
    do_write(17'h00123, 1, 1'b1, "R5 locked write");
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk("R5 no write window after locked write", ack, 1);
    do_read(17'h00123, 1, "R5 locked location unchanged");

    // R4: stop mid-byte and start after data both discard
    wbuf[0] = 8'h10;
    do_write(17'h00200, 1, 1'b0, "R4 setup");
    wait_ready("R4");
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack); send_byte(8'h02, ack); send_byte(8'h00, ack);
    send_byte(8'h77, ack); chk("R4 data acked before abort", ack, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk("R4 no write window after mid-byte stop", ack, 1);
    do_read(17'h00200, 1, "R4 memory unchanged after mid-byte stop");
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack); send_byte(8'h02, ack); send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    do_read(17'h00200, 1, "R12 R4 repeated start discards data");

    // R12: start in the middle of a select byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    do_read(17'h00124, 1, "R12 resync after partial byte");

    // R10: wrap from top address to zero
    wbuf[0] = 8'hA1;
    do_write(17'h00000, 1, 1'b0, "R10 setup low");
    wait_ready("R10");
    wbuf[0] = 8'hB2;
    do_write(17'h1FFFF, 1, 1'b0, "R10 setup top");
    wait_ready("R10");
    do_read(17'h1FFFF, 2, "R10 counter wraps to zero");

    // R9: NoAck puts the core in standby; further clocks see no drive
    do_read(17'h00000, 1, "R9 read before standby");
    bus_start();
    send_byte(sel(1'b0, 1'b1), ack);
    recv_byte(1'b0, b, slot);
    recv_byte(1'b0, b, slot);
    chk("R9 no drive after master NoAck", b, 8'hFF);
    bus_stop();

    // Random write / locked overwrite / read back
    for (int it = 0; it < 8; it++) begin
      chip_sel = 2'($urandom);
      ra = 17'($urandom);
      ra[6:0] = 7'($urandom_range(0, 124));
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(ra, n, 1'b0, "R3 random write");
      wait_ready("R3 random");
      for (int k = 0; k < n; k++) wbuf[k] = ~wbuf[k];
      do_write(ra, n, 1'b1, "R5 random locked write");
      do_read(ra, n, "R9 random sequential read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule